// File: doc/BRIEF.md
# Serial Audio Link Command Decoder

This block is the codec-side receiver for the command part of a serial audio output frame. It samples one serial data line on every bit-clock edge and takes a frame start from the rising edge of the sync line. It collects the tag slot, the command address slot and the command data slot. It also captures the eight playback sample slots and presents them on a wide output.

At the end of the command data slot the block judges whether the frame carries a register access meant for this codec. The frame-valid flag, the codec identity and the slot-valid flags must fit the configured primary or secondary role, and the word index must be even. An accepted write updates a 64-word internal register file. An accepted read returns the index and the stored word on a status port at the start of the next frame.

Top module: `cmd_link_decoder`

## Requirements
- R1: A frame starts on the clock edge where `frm_sync` is sampled high after being sampled low. That edge samples tag bit 0. A frame is 256 bits, MSB first: a 16-bit tag, then twelve 20-bit slots. After bit 255, further bits are ignored until the next sync rise. A sync rise at any point restarts the frame.
- R2: Tag fields are bit 15 = frame valid, bit 14 = slot 1 valid, bit 13 = slot 2 valid, and bits 1:0 = codec ID, with bit 1 as the MSB. The codec ID is compared with `cfg_codec_id`.
- R3: In slot 1, bit 19 = 1 means read and bit 19 = 0 means write. Bits 18:12 hold the 7-bit index. In slot 2, bits 19:4 hold the write data, and slot 2 has no effect on a read.
- R4: No access happens unless the frame-valid bit is set and the tag codec ID equals `cfg_codec_id`.
- R5: With `cfg_secondary` = 0 (primary role), a read needs slot 1 valid set, and a write needs both slot 1 valid and slot 2 valid set.
- R6: With `cfg_secondary` = 1 (secondary role), slot 1 valid and slot 2 valid must both be clear for a read or a write.
- R7: An access whose index has bit 0 set is ignored: nothing is written and no status is returned.
- R8: The command is decoded on the edge that samples the last bit of slot 2 (frame bit 55). A frame cut short by a new sync rise before that bit makes no access.
- R9: An accepted write stores the write data in word index[6:1]. All words reset to zero.
- R10: An accepted read raises `stat_valid` for exactly one cycle, starting just after the edge that samples tag bit 0 of the next frame. At that point `stat_index` holds the index and `stat_data` holds the word as it was at decode time. Both hold their values until the next read is reported.
- R11: Slots 3 to 10 appear on `pcm_data`, with slot 3 in bits 19:0 and slot 10 in bits 159:140. `pcm_strobe` pulses for one cycle after the edge that samples frame bit 215, and at that point all eight samples belong to the current frame.
- R12: A synchronous active-high reset clears all outputs and leaves the receiver idle until the first sync rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Bit clock; the inputs are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| frm_sync | input | 1 | Frame sync line; a rising edge marks tag bit 0 |
| ser_din | input | 1 | Serial frame data, MSB first |
| cfg_codec_id | input | 2 | Codec identity this block answers to |
| cfg_secondary | input | 1 | 1 selects the secondary-role slot-valid rule |
| stat_valid | output | 1 | One-cycle pulse announcing read data |
| stat_index | output | 7 | Index of the reported read |
| stat_data | output | 16 | Word returned by the reported read |
| pcm_strobe | output | 1 | One-cycle pulse when all playback samples of a frame are held |
| pcm_data | output | 160 | Eight 20-bit playback samples, slot 3 lowest |

## Verification
The bench builds the block with its default parameters: a 16-bit tag, twelve 20-bit slots, a 7-bit index and eight playback slots starting at slot 3. With these values, the full 256-bit frame and the 64-word register file are exercised at their real sizes. During the run the bench changes the configured codec ID and switches between the primary and secondary roles, which brings both slot-valid rules and the ID comparison within reach. Truncated frames and long idle gaps bring the restart and ignore paths of the bit counter into play.

// File: rtl/cmdlink_pkg.sv
package cmdlink_pkg;

  localparam int CODEC_ID_W = 2;

  typedef struct packed {
    logic                  frame_ok;
    logic                  s1_ok;
    logic                  s2_ok;
    logic [CODEC_ID_W-1:0] id;
  } tag_t;

  // Frame bit position of the last bit of slot k (k = 0 is the tag).
  function automatic int slot_last(input int k, input int tag_w, input int slot_w);
    return tag_w + k * slot_w - 1;
  endfunction

  // Role, identity and slot-valid qualification of one command.
  function automatic logic tag_permits(input tag_t t, input logic is_read,
                                       input logic secondary,
                                       input logic [CODEC_ID_W-1:0] my_id);
    logic slots_ok;
    if (secondary)    slots_ok = !t.s1_ok && !t.s2_ok;
    else if (is_read) slots_ok = t.s1_ok;
    else              slots_ok = t.s1_ok && t.s2_ok;
    return t.frame_ok && (t.id == my_id) && slots_ok;
  endfunction

endpackage

// File: rtl/cmdlink_framer.sv
module cmdlink_framer #(
  parameter int TAG_W     = 16,
  parameter int SLOT_W    = 20,
  parameter int NUM_SLOTS = 12,
  parameter int CNT_W     = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sync_i,
  input  logic              sdata_i,
  output logic              sync_rise_o,
  output logic              bit_act_o,
  output logic [CNT_W-1:0]  pos_o,
  output logic [SLOT_W-1:0] word_o
);

  localparam int FRAME_LEN = TAG_W + NUM_SLOTS * SLOT_W;
  localparam logic [CNT_W-1:0] IDLE = CNT_W'(FRAME_LEN);

  logic              sync_d;
  logic [CNT_W-1:0]  cnt;
  logic [SLOT_W-2:0] sh;

  assign sync_rise_o = sync_i & ~sync_d;
  assign pos_o       = sync_rise_o ? '0 : cnt;
  assign bit_act_o   = sync_rise_o | (cnt != IDLE);
  assign word_o      = {sh, sdata_i};

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_d <= 1'b0;
      cnt    <= IDLE;
      sh     <= '0;
    end else begin
      sync_d <= sync_i;
      sh     <= {sh[SLOT_W-3:0], sdata_i};
      if (bit_act_o) cnt <= pos_o + 1'b1;
    end
  end

endmodule

// File: rtl/cmdlink_qualify.sv
module cmdlink_qualify
  import cmdlink_pkg::*;
(
  input  logic                  fire_i,
  input  tag_t                  tag_i,
  input  logic                  is_read_i,
  input  logic                  idx_lsb_i,
  input  logic                  secondary_i,
  input  logic [CODEC_ID_W-1:0] codec_id_i,
  output logic                  wr_en_o,
  output logic                  rd_en_o
);

  logic accept;

  assign accept  = fire_i && !idx_lsb_i &&
                   tag_permits(tag_i, is_read_i, secondary_i, codec_id_i);
  assign wr_en_o = accept && !is_read_i;
  assign rd_en_o = accept && is_read_i;

endmodule

// File: rtl/cmdlink_regfile.sv
module cmdlink_regfile #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  localparam int DEPTH = 2 ** ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  assign rdata = mem[addr];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[addr] <= wdata;
    end
  end

endmodule

// File: rtl/cmd_link_decoder.sv
module cmd_link_decoder
  import cmdlink_pkg::*;
#(
  parameter int TAG_W     = 16,
  parameter int SLOT_W    = 20,
  parameter int NUM_SLOTS = 12,
  parameter int IDX_W     = 7,
  parameter int DATA_W    = 16,
  parameter int PCM_FIRST = 3,
  parameter int PCM_COUNT = 8
) (
  input  logic                        bclk,
  input  logic                        rst,
  input  logic                        frm_sync,
  input  logic                        ser_din,
  input  logic [CODEC_ID_W-1:0]       cfg_codec_id,
  input  logic                        cfg_secondary,
  output logic                        stat_valid,
  output logic [IDX_W-1:0]            stat_index,
  output logic [DATA_W-1:0]           stat_data,
  output logic                        pcm_strobe,
  output logic [PCM_COUNT*SLOT_W-1:0] pcm_data
);

  localparam int FRAME_LEN = TAG_W + NUM_SLOTS * SLOT_W;
  localparam int CNT_W     = $clog2(FRAME_LEN + 1);
  localparam int AW        = IDX_W - 1;
  localparam logic [CNT_W-1:0] TAG_END = CNT_W'(slot_last(0, TAG_W, SLOT_W));
  localparam logic [CNT_W-1:0] S1_END  = CNT_W'(slot_last(1, TAG_W, SLOT_W));
  localparam logic [CNT_W-1:0] S2_END  = CNT_W'(slot_last(2, TAG_W, SLOT_W));
  localparam logic [CNT_W-1:0] PCM_END =
    CNT_W'(slot_last(PCM_FIRST + PCM_COUNT - 1, TAG_W, SLOT_W));

  // Named internal events, also observed by the bound checker.
  logic              sync_rise, bit_act;
  logic [CNT_W-1:0]  pos;
  logic [SLOT_W-1:0] word;
  logic              cmd_fire, wr_en, rd_en;
  tag_t              tag_q;
  logic              cmd_rd;
  logic [IDX_W-1:0]  cmd_idx;
  logic [DATA_W-1:0] rf_rdata;
  logic              rd_pend;
  logic [IDX_W-1:0]  rd_idx;
  logic [DATA_W-1:0] rd_dat;
  logic [PCM_COUNT-1:0] pcm_hit;
  logic [SLOT_W-1:0] pcm_q [PCM_COUNT];

  cmdlink_framer #(
    .TAG_W(TAG_W), .SLOT_W(SLOT_W), .NUM_SLOTS(NUM_SLOTS), .CNT_W(CNT_W)
  ) u_framer (
    .clk(bclk), .rst(rst), .sync_i(frm_sync), .sdata_i(ser_din),
    .sync_rise_o(sync_rise), .bit_act_o(bit_act), .pos_o(pos), .word_o(word)
  );

  assign cmd_fire = bit_act && (pos == S2_END);

  cmdlink_qualify u_qual (
    .fire_i(cmd_fire), .tag_i(tag_q), .is_read_i(cmd_rd),
    .idx_lsb_i(cmd_idx[0]), .secondary_i(cfg_secondary),
    .codec_id_i(cfg_codec_id), .wr_en_o(wr_en), .rd_en_o(rd_en)
  );

  cmdlink_regfile #(.DATA_W(DATA_W), .ADDR_W(AW)) u_rf (
    .clk(bclk), .rst(rst), .we(wr_en), .addr(cmd_idx[IDX_W-1:1]),
    .wdata(word[SLOT_W-1 -: DATA_W]), .rdata(rf_rdata)
  );

  // Command slots and read return path.
  always_ff @(posedge bclk) begin
    if (rst) begin
      tag_q      <= '0;
      cmd_rd     <= 1'b0;
      cmd_idx    <= '0;
      rd_pend    <= 1'b0;
      rd_idx     <= '0;
      rd_dat     <= '0;
      stat_valid <= 1'b0;
      stat_index <= '0;
      stat_data  <= '0;
      pcm_strobe <= 1'b0;
    end else begin
      if (bit_act && pos == TAG_END)
        tag_q <= '{frame_ok: word[TAG_W-1], s1_ok: word[TAG_W-2],
                   s2_ok: word[TAG_W-3], id: word[CODEC_ID_W-1:0]};
      if (bit_act && pos == S1_END) begin
        cmd_rd  <= word[SLOT_W-1];
        cmd_idx <= word[SLOT_W-2 -: IDX_W];
      end
      stat_valid <= 1'b0;
      if (rd_en) begin
        rd_pend <= 1'b1;
        rd_idx  <= cmd_idx;
        rd_dat  <= rf_rdata;
      end else if (sync_rise && rd_pend) begin
        stat_valid <= 1'b1;
        stat_index <= rd_idx;
        stat_data  <= rd_dat;
        rd_pend    <= 1'b0;
      end
      pcm_strobe <= bit_act && (pos == PCM_END);
    end
  end

  // Playback sample capture, one slot-end detector per sample.
  for (genvar j = 0; j < PCM_COUNT; j++) begin : g_pcm
    assign pcm_hit[j] = bit_act &&
      (pos == CNT_W'(slot_last(PCM_FIRST + j, TAG_W, SLOT_W)));
    assign pcm_data[j*SLOT_W +: SLOT_W] = pcm_q[j];
  end

  always_ff @(posedge bclk) begin
    if (rst) begin
      for (int j = 0; j < PCM_COUNT; j++) pcm_q[j] <= '0;
    end else begin
      for (int j = 0; j < PCM_COUNT; j++)
        if (pcm_hit[j]) pcm_q[j] <= word;
    end
  end

endmodule

// File: rtl/cmd_link_decoder_chk.sv
module cmd_link_decoder_chk #(
  parameter int CNT_W     = 9,
  parameter int FRAME_LEN = 256,
  parameter int S2_END    = 55,
  parameter int PCM_END   = 215
) (
  input logic             clk,
  input logic             rst,
  input logic             sync_rise,
  input logic             bit_act,
  input logic [CNT_W-1:0] pos,
  input logic             wr_en,
  input logic             rd_en,
  input logic             idx_lsb,
  input logic             rd_pend,
  input logic             stat_valid,
  input logic             pcm_strobe,
  input logic             cfg_secondary,
  input logic             tag_s1,
  input logic             tag_s2
);

  // R1: the frame position never runs past the frame length
  p_pos_range_r1: assert property (@(posedge clk) disable iff (rst)
    bit_act |-> (int'(pos) < FRAME_LEN));

  // R1: a sync rise restarts counting, so the next bit is bit 1
  p_restart_r1: assert property (@(posedge clk) disable iff (rst)
    sync_rise |=> (bit_act && pos == CNT_W'(1)));

  // R8: accesses are issued only on the last bit of slot 2
  p_decode_point_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_en || rd_en) |-> (bit_act && int'(pos) == S2_END));

  // R7: odd indices never produce an access
  p_even_index_r7: assert property (@(posedge clk) disable iff (rst)
    (wr_en || rd_en) |-> !idx_lsb);

  // R6: in the secondary role both slot-valid flags are clear
  p_secondary_r6: assert property (@(posedge clk) disable iff (rst)
    ((wr_en || rd_en) && cfg_secondary) |-> (!tag_s1 && !tag_s2));

  // R10: an accepted read leaves a pending status
  p_read_pending_r10: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_pend);

  // R10: the status pulse lasts one cycle
  p_stat_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    stat_valid |=> !stat_valid);

  // R10: the status pulse follows a frame start
  p_stat_at_frame_r10: assert property (@(posedge clk) disable iff (rst)
    stat_valid |-> $past(sync_rise));

  // R11: the sample strobe follows the last bit of the last sample slot
  p_pcm_strobe_r11: assert property (@(posedge clk) disable iff (rst)
    pcm_strobe |-> (int'($past(pos)) == PCM_END && $past(bit_act)));

endmodule

bind cmd_link_decoder cmd_link_decoder_chk #(
  .CNT_W(CNT_W), .FRAME_LEN(FRAME_LEN),
  .S2_END(int'(S2_END)), .PCM_END(int'(PCM_END))
) u_chk (
  .clk(bclk), .rst(rst), .sync_rise(sync_rise), .bit_act(bit_act),
  .pos(pos), .wr_en(wr_en), .rd_en(rd_en), .idx_lsb(cmd_idx[0]),
  .rd_pend(rd_pend), .stat_valid(stat_valid), .pcm_strobe(pcm_strobe),
  .cfg_secondary(cfg_secondary), .tag_s1(tag_q.s1_ok), .tag_s2(tag_q.s2_ok)
);

// File: tb/cmd_link_decoder_tb.sv
module cmd_link_decoder_tb;

  logic         bclk = 1'b0;
  logic         rst = 1'b1;
  logic         frm_sync = 1'b0;
  logic         ser_din = 1'b0;
  logic [1:0]   cfg_codec_id = 2'd1;
  logic         cfg_secondary = 1'b0;
  logic         stat_valid;
  logic [6:0]   stat_index;
  logic [15:0]  stat_data;
  logic         pcm_strobe;
  logic [159:0] pcm_data;

  always #5 bclk = ~bclk;

  cmd_link_decoder u_dut (
    .bclk(bclk), .rst(rst), .frm_sync(frm_sync), .ser_din(ser_din),
    .cfg_codec_id(cfg_codec_id), .cfg_secondary(cfg_secondary),
    .stat_valid(stat_valid), .stat_index(stat_index), .stat_data(stat_data),
    .pcm_strobe(pcm_strobe), .pcm_data(pcm_data)
  );

  int total = 0;
  int bad = 0;
  string cur_req = "R12";

  // Behavioural reference state.
  int           last_pos = -1;
  logic [15:0]  m_mem [int];
  bit           m_pend = 0;
  logic [6:0]   m_idx = '0;
  logic [15:0]  m_dat = '0;
  logic [6:0]   e_idx = '0;
  logic [15:0]  e_dat = '0;
  logic [15:0]  cur_tag = '0;
  logic [19:0]  cur_a = '0, cur_d = '0;
  logic [159:0] cur_pcm = '0;

  task automatic chk(input bit ok, input string what, input logic [159:0] act,
                     input logic [159:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s (%s) act=%h exp=%h", cur_req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] mem_rd(input int a);
    return m_mem.exists(a) ? m_mem[a] : 16'h0;
  endfunction

  // Model outcome of the bit sampled on the last edge, then compare.
  task automatic step();
    bit e_sv = 0;
    bit e_ps;
    if (last_pos == 0 && m_pend) begin
      e_sv = 1; e_idx = m_idx; e_dat = m_dat; m_pend = 0;
    end
    if (last_pos == 55) begin
      bit rd = cur_a[19];
      logic [6:0] idx = cur_a[18:12];
      bit role_ok;
      bit ok;
      if (cfg_secondary) role_ok = !cur_tag[14] && !cur_tag[13];
      else role_ok = rd ? cur_tag[14] : (cur_tag[14] && cur_tag[13]);
      ok = cur_tag[15] && (cur_tag[1:0] == cfg_codec_id) && !idx[0] && role_ok;
      if (ok && rd) begin
        m_pend = 1; m_idx = idx; m_dat = mem_rd(int'(idx) / 2);
      end else if (ok) begin
        m_mem[int'(idx) / 2] = cur_d[19:4];
      end
    end
    e_ps = (last_pos == 215);
    chk(stat_valid === e_sv, "R10 stat_valid", 160'(stat_valid), 160'(e_sv));
    chk(stat_index === e_idx, "R10 stat_index", 160'(stat_index), 160'(e_idx));
    chk(stat_data === e_dat, "R10 stat_data", 160'(stat_data), 160'(e_dat));
    chk(pcm_strobe === e_ps, "R11 pcm_strobe", 160'(pcm_strobe), 160'(e_ps));
    if (e_ps) chk(pcm_data === cur_pcm, "R11 pcm_data", pcm_data, cur_pcm);
  endtask

  function automatic logic [15:0] mk_tag(input bit fv, input bit s1, input bit s2,
                                         input logic [1:0] id);
    return {fv, s1, s2, 11'h0, id};
  endfunction

  function automatic logic [159:0] mk_pcm(input int seed);
    logic [159:0] v;
    for (int j = 0; j < 8; j++) v[j*20 +: 20] = 20'((seed * 40503 + j * 9973) ^ (j << 15));
    return v;
  endfunction

  task automatic send_frame(input logic [15:0] tg, input bit rd, input logic [6:0] idx,
                            input logic [19:0] d, input int seed, input int nbits);
    logic [255:0] frm;
    logic [19:0]  a = {rd, idx, 12'h0};
    logic [159:0] pv = mk_pcm(seed);
    frm = '0;
    frm[255 -: 16] = tg;
    frm[239 -: 20] = a;
    frm[219 -: 20] = d;
    for (int j = 0; j < 8; j++) frm[199 - 20*j -: 20] = pv[j*20 +: 20];
    for (int i = 0; i < nbits; i++) begin
      @(negedge bclk);
      step();
      if (i == 0) begin
        cur_tag = tg; cur_a = a; cur_d = d; cur_pcm = pv;
      end
      frm_sync = (i < 16);
      ser_din  = frm[255 - i];
      last_pos = i;
    end
  endtask

  task automatic wr(input logic [6:0] idx, input logic [15:0] v, input logic [15:0] tg);
    send_frame(tg, 1'b0, idx, {v, 4'h0}, int'(v), 256);
  endtask

  task automatic rd(input logic [6:0] idx, input logic [15:0] tg);
    send_frame(tg, 1'b1, idx, 20'hA5C3F, int'(idx) + 7, 256);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge bclk);
      step();
      frm_sync = 1'b0;
      ser_din  = i[0] ^ i[2];
      last_pos = -1;
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge bclk);
    bad++;
    $display("FAIL watchdog expired act=running exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [15:0] p_ok, p_rd;
    repeat (3) @(negedge bclk);
    rst = 1'b0;
    // R12: outputs cleared and idle after reset
    cur_req = "R12";
    chk(pcm_data === '0, "R12 pcm_data", pcm_data, '0);
    idle(20);

    p_ok = mk_tag(1, 1, 1, 2'd1);
    p_rd = mk_tag(1, 1, 0, 2'd1);
    cur_req = "R3 R5 R9";
    wr(7'h10, 16'hBEEF, p_ok);
    rd(7'h10, p_rd);
    wr(7'h04, 16'h0123, p_ok);
    rd(7'h04, p_ok);

    cur_req = "R5";
    wr(7'h10, 16'h1111, p_rd);                 // slot 2 valid clear: no write
    rd(7'h10, mk_tag(1, 0, 0, 2'd1));         // slot 1 valid clear: no read
    rd(7'h10, p_rd);

    cur_req = "R2 R4";
    wr(7'h10, 16'h2222, mk_tag(0, 1, 1, 2'd1));
    wr(7'h10, 16'h3333, mk_tag(1, 1, 1, 2'd2));
    rd(7'h10, mk_tag(1, 1, 0, 2'd3));
    rd(7'h10, p_rd);

    cur_req = "R7";
    wr(7'h11, 16'h4444, p_ok);
    rd(7'h11, p_rd);
    wr(7'h12, 16'h5555, p_ok);
    rd(7'h12, p_rd);
    rd(7'h10, p_rd);

    cur_req = "R8";
    send_frame(p_ok, 1'b0, 7'h20, {16'h6666, 4'h0}, 3, 50);
    send_frame(p_ok, 1'b0, 7'h22, {16'h7777, 4'h0}, 4, 55);
    rd(7'h20, p_rd);
    rd(7'h22, p_rd);

    cur_req = "R1";
    idle(300);
    rd(7'h12, p_rd);
    idle(40);
    wr(7'h7E, 16'hFACE, p_ok);
    rd(7'h7E, p_rd);

    cur_req = "R6";
    cfg_secondary = 1'b1;
    cfg_codec_id  = 2'd2;
    wr(7'h30, 16'h5A5A, mk_tag(1, 0, 0, 2'd2));
    wr(7'h30, 16'h6B6B, mk_tag(1, 1, 1, 2'd2));
    rd(7'h30, mk_tag(1, 1, 0, 2'd2));
    rd(7'h30, mk_tag(1, 0, 0, 2'd2));
    wr(7'h30, 16'h7C7C, mk_tag(1, 0, 1, 2'd2));
    rd(7'h30, mk_tag(1, 0, 0, 2'd2));

    cur_req = "R11";
    send_frame(16'h0, 1'b0, 7'h0, 20'h0, 99, 256);
    idle(10);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule